// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is the pin-facing half of one timer channel. It owns a general register and one pin, and a 4-bit mode field decides what the pair does. In the compare role, the pin is driven to a chosen starting level as soon as the mode is written. Each time an external free-running counter comes to equal the register, the pin is then cleared, set or toggled. In the capture role, the register takes a snapshot of the counter. The snapshot is triggered either by an edge on the (synchronized) pin or by a count strobe from a neighbouring channel.

A buffer-mode flag turns the register into a plain holding register: no compare events and no captures are produced. A flag saying that the neighbour counter runs from the undivided clock blocks the neighbour-triggered capture. Every compare match or capture produces a single-cycle event pulse. All pins are plain level or strobe signals. The event pulse has no back-pressure: it cannot be stalled, so a consumer that needs it must sample it in the cycle it appears.

Top module: `tmr_cc_chan`

## Requirements
- R1: While reset is active and after it is released, pin_o, pin_oe_o, evt_o and reg_o are all 0, and the mode field is 0000.
- R2: pin_oe_o is 1 only when the mode field holds the pattern 0 x y z with yz not equal to 00. It is 0 for 0000, 0100 and every mode with bit 3 set.
- R3: When a driving output mode is written, pin_o takes mode bit 2 in the cycle after the write, before any compare match.
- R4: A compare match is the first cycle in which cnt_i equals reg_o after a cycle in which they differed, while mode bit 3 is 0. One clock later evt_o is 1 and pin_o follows mode bits [1:0]: 01 gives 0, 10 gives 1, 11 inverts it. For modes 0000 and 0100, evt_o still pulses and pin_o stays 0.
- R5: For mode 1000 a rising pin edge triggers a capture, for 1001 a falling edge, and for 1010 and 1011 either edge. The pin passes through two synchronizer flops and a previous-sample flop. After the third rising clock edge following a pin change, reg_o holds the cnt_i value that was present just before that edge, and evt_o is 1.
- R6: While buf_mode_i is 1, no compare match and no capture takes effect: evt_o stays 0, reg_o and pin_o are untouched. A mode write still applies its starting level.
- R7: In modes 11xx, a capture happens at the clock edge where nbr_cnt_stb_i is 1 and nbr_undiv_i is 0. It is suppressed when nbr_undiv_i is 1. Pin edges are ignored in these modes.
- R8: evt_o is high for exactly one cycle per isolated match or capture.
- R9: reg_wr_en_i loads reg_o with reg_wr_data_i at the next edge. This write wins over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| mode_we_i | input | 1 | Mode field write strobe |
| mode_wdata_i | input | 4 | New mode field value |
| reg_wr_en_i | input | 1 | General register write strobe |
| reg_wr_data_i | input | CNT_W | General register write value |
| buf_mode_i | input | 1 | Register used as buffer; suppresses match and capture |
| pin_i | input | 1 | Asynchronous pin input |
| nbr_cnt_stb_i | input | 1 | Neighbour channel count strobe |
| nbr_undiv_i | input | 1 | Neighbour counter clocked by undivided clock |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| reg_o | output | CNT_W | General register value |
| evt_o | output | 1 | One-cycle compare/capture event |

## Verification
A wrong decoded mode or a stale starting level shows at pin_oe_o and pin_o one clock after the mode write. A broken edge detector or synchronizer depth moves the capture by a cycle, which shows as a wrong reg_o value three edges after the pin change. A missing equality history shows as repeated evt_o pulses while the counter dwells on the compare value. A leak through the buffer or undivided-clock suppression gives an evt_o pulse one clock after the trigger.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } tmr_cc_act_e;

  typedef enum logic [1:0] {
    SRC_RISE = 2'b00,
    SRC_FALL = 2'b01,
    SRC_BOTH = 2'b10,
    SRC_NBR  = 2'b11
  } tmr_cc_src_e;

  typedef struct packed {
    logic        is_cap;
    logic        drive;
    logic        init_lvl;
    tmr_cc_act_e act;
    tmr_cc_src_e src;
  } tmr_cc_cfg_t;

  function automatic tmr_cc_cfg_t tmr_cc_decode(input logic [MODE_W-1:0] m);
    tmr_cc_cfg_t c;
    c.is_cap   = m[3];
    c.drive    = ~m[3] & (m[1:0] != 2'b00);
    c.init_lvl = m[2];
    c.act      = tmr_cc_act_e'(m[1:0]);
    if (m[3:2] == 2'b11)  c.src = SRC_NBR;
    else if (m[1])        c.src = SRC_BOTH;
    else if (m[0])        c.src = SRC_FALL;
    else                  c.src = SRC_RISE;
    return c;
  endfunction

endpackage

// File: rtl/tmr_cc_insync.sv
module tmr_cc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              sync_w;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign sync_w = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_w;
  end

  assign rise_o = sync_w & ~prev_q;
  assign fall_o = ~sync_w & prev_q;

endmodule

// File: rtl/tmr_cc_ctl.sv
module tmr_cc_ctl
  import tmr_cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_q_o,
  output tmr_cc_cfg_t       cfg_o,
  output tmr_cc_cfg_t       new_cfg_o,
  output logic              load_o
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  assign mode_q_o  = mode_q;
  assign cfg_o     = tmr_cc_decode(mode_q);
  assign new_cfg_o = tmr_cc_decode(mode_wdata_i);
  assign load_o    = mode_we_i;

endmodule

// File: rtl/tmr_cc_trig.sv
module tmr_cc_trig
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cc_cfg_t      cfg_i,
  input  logic             buf_mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             nbr_stb_i,
  input  logic             nbr_undiv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] reg_i,
  output logic             cap_fire_o,
  output logic             cmp_fire_o
);

  logic eq_w;
  logic eq_q;
  logic edge_w;

  assign eq_w = (cnt_i == reg_i);

  // Reset to 1 so that a counter and register both at zero after reset
  // do not count as a fresh match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b1;
    else        eq_q <= eq_w;
  end

  always_comb begin
    unique case (cfg_i.src)
      SRC_RISE: edge_w = rise_i;
      SRC_FALL: edge_w = fall_i;
      SRC_BOTH: edge_w = rise_i | fall_i;
      SRC_NBR:  edge_w = nbr_stb_i & ~nbr_undiv_i;
      default:  edge_w = 1'b0;
    endcase
  end

  assign cap_fire_o =  cfg_i.is_cap & ~buf_mode_i & edge_w;
  assign cmp_fire_o = ~cfg_i.is_cap & ~buf_mode_i & eq_w & ~eq_q;

endmodule

// File: rtl/tmr_cc_pinout.sv
module tmr_cc_pinout
  import tmr_cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  tmr_cc_cfg_t new_cfg_i,
  input  tmr_cc_cfg_t cfg_i,
  input  logic        cmp_fire_i,
  output logic        pin_o,
  output logic        pin_oe_o
);

  logic pin_q;
  logic pin_nxt;

  always_comb begin
    pin_nxt = pin_q;
    if (load_i) begin
      pin_nxt = new_cfg_i.drive & new_cfg_i.init_lvl;
    end else if (cmp_fire_i && cfg_i.drive) begin
      unique case (cfg_i.act)
        ACT_LOW:  pin_nxt = 1'b0;
        ACT_HIGH: pin_nxt = 1'b1;
        ACT_FLIP: pin_nxt = ~pin_q;
        default:  pin_nxt = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_nxt;
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = cfg_i.drive;

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              reg_wr_en_i,
  input  logic [CNT_W-1:0]  reg_wr_data_i,
  input  logic              buf_mode_i,
  input  logic              pin_i,
  input  logic              nbr_cnt_stb_i,
  input  logic              nbr_undiv_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic [CNT_W-1:0]  reg_o,
  output logic              evt_o
);

  logic [MODE_W-1:0] mode_q;
  tmr_cc_cfg_t       cfg;
  tmr_cc_cfg_t       new_cfg;
  logic              load;
  logic              rise;
  logic              fall;
  logic              cap_fire;
  logic              cmp_fire;
  logic [CNT_W-1:0]  reg_q;
  logic              evt_q;

  tmr_cc_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .mode_q_o     (mode_q),
    .cfg_o        (cfg),
    .new_cfg_o    (new_cfg),
    .load_o       (load)
  );

  tmr_cc_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_cc_trig #(.CNT_W(CNT_W)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .buf_mode_i  (buf_mode_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .nbr_stb_i   (nbr_cnt_stb_i),
    .nbr_undiv_i (nbr_undiv_i),
    .cnt_i       (cnt_i),
    .reg_i       (reg_q),
    .cap_fire_o  (cap_fire),
    .cmp_fire_o  (cmp_fire)
  );

  tmr_cc_pinout u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .new_cfg_i  (new_cfg),
    .cfg_i      (cfg),
    .cmp_fire_i (cmp_fire),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  // Register: a bus write wins over a capture in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           reg_q <= '0;
    else if (reg_wr_en_i) reg_q <= reg_wr_data_i;
    else if (cap_fire)    reg_q <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= cap_fire | cmp_fire;
  end

  assign reg_o = reg_q;
  assign evt_o = evt_q;

endmodule

// File: rtl/tmr_cc_chan_chk.sv
module tmr_cc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we_i,
  input logic             reg_wr_en_i,
  input logic             buf_mode_i,
  input logic             nbr_undiv_i,
  input logic [3:0]       mode_q,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic [CNT_W-1:0] reg_o,
  input logic             evt_o
);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!pin_o && !pin_oe_o && !evt_o && reg_o == '0)
        else $error("a_r1_reset_quiet");
    end
  end

  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] || mode_q[1:0] == 2'b00) |-> !pin_oe_o);

  a_r4_pin_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> ($past(mode_we_i) || evt_o));

  a_r6_buf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode_i |=> !evt_o);

  a_r7_undiv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11 && nbr_undiv_i) |=> !evt_o);

  a_r9_reg_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_o) |-> ($past(reg_wr_en_i) || evt_o));

endmodule

bind tmr_cc_chan tmr_cc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_we_i   (mode_we_i),
  .reg_wr_en_i (reg_wr_en_i),
  .buf_mode_i  (buf_mode_i),
  .nbr_undiv_i (nbr_undiv_i),
  .mode_q      (mode_q),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .reg_o       (reg_o),
  .evt_o       (evt_o)
);

// File: tb/tmr_cc_chan_bench.sv
module tmr_cc_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CMP_VAL = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic mode_we_i = 1'b0;
  logic [3:0] mode_wdata_i = '0;
  logic reg_wr_en_i = 1'b0;
  logic [CNT_W-1:0] reg_wr_data_i = '0;
  logic buf_mode_i = 1'b0;
  logic pin_i = 1'b0;
  logic nbr_cnt_stb_i = 1'b0;
  logic nbr_undiv_i = 1'b0;
  logic pin_o, pin_oe_o, evt_o;
  logic [CNT_W-1:0] reg_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cc_chan #(.CNT_W(CNT_W)) u_tmr_cc_chan (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .reg_wr_en_i(reg_wr_en_i), .reg_wr_data_i(reg_wr_data_i),
    .buf_mode_i(buf_mode_i), .pin_i(pin_i),
    .nbr_cnt_stb_i(nbr_cnt_stb_i), .nbr_undiv_i(nbr_undiv_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .reg_o(reg_o), .evt_o(evt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we_i = 1'b1; mode_wdata_i = m;
    tick();
    mode_we_i = 1'b0;
  endtask

  task automatic load_reg(input logic [CNT_W-1:0] v);
    reg_wr_en_i = 1'b1; reg_wr_data_i = v;
    tick();
    reg_wr_en_i = 1'b0;
  endtask

  // Pin change, then counter value v set after the second edge;
  // capture lands on the third edge.
  task automatic pin_edge(input logic lvl, input logic [CNT_W-1:0] v);
    pin_i = lvl;
    tick();
    tick();
    cnt_i = v;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] exp_reg;
    repeat (3) tick();
    // R1: reset state
    check(pin_o == 0 && pin_oe_o == 0 && evt_o == 0 && reg_o == 0, "R1",
          "outputs in reset", {pin_o, pin_oe_o, evt_o}, 0);
    rst_n = 1'b1;
    tick(); tick();
    check(pin_oe_o == 0 && evt_o == 0 && reg_o == 0, "R1", "outputs after reset",
          {pin_oe_o, evt_o}, 0);

    // R9: register write
    load_reg(16'hBEEF);
    check(reg_o == 16'hBEEF, "R9", "reg write", reg_o, 16'hBEEF);

    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] mv;
        logic oe, lvl, pexp;
        mv = 4'(m);
        buf_mode_i = 1'(b);
        pin_i = 1'b0; nbr_cnt_stb_i = 1'b0; nbr_undiv_i = 1'b0; cnt_i = '0;
        repeat (4) tick();
        load_reg(CMP_VAL);
        exp_reg = CMP_VAL;
        set_mode(mv);
        oe  = !mv[3] && (mv[1:0] != 2'b00);
        lvl = oe ? mv[2] : 1'b0;
        check(pin_oe_o == oe, "R2", $sformatf("oe mode %0d buf %0d", m, b), pin_oe_o, oe);
        check(pin_o == lvl, "R3", $sformatf("initial level mode %0d buf %0d", m, b), pin_o, lvl);
        tick();
        check(evt_o == 0 && pin_o == lvl, "R4", $sformatf("no event before match mode %0d", m),
              {evt_o, pin_o}, {1'b0, lvl});
        if (!mv[3]) begin
          cnt_i = CMP_VAL;
          tick();
          pexp = lvl;
          if (!b && oe) begin
            case (mv[1:0])
              2'b01: pexp = 1'b0;
              2'b10: pexp = 1'b1;
              default: pexp = ~lvl;
            endcase
          end
          check(evt_o == !b, b ? "R6" : "R4", $sformatf("match flag mode %0d", m), evt_o, !b);
          check(pin_o == pexp, b ? "R6" : "R4", $sformatf("match pin mode %0d", m), pin_o, pexp);
          tick();
          check(evt_o == 0, "R8", $sformatf("single pulse while equal mode %0d", m), evt_o, 0);
          check(pin_o == pexp, "R8", $sformatf("no repeat action mode %0d", m), pin_o, pexp);
          cnt_i = '0; tick();
          cnt_i = CMP_VAL; tick();
          if (!b && mv[1:0] == 2'b11) pexp = lvl;
          check(pin_o == pexp, b ? "R6" : "R4", $sformatf("second match mode %0d", m), pin_o, pexp);
        end else begin
          logic rexp, fexp, capn;
          capn = (mv[3:2] == 2'b10);
          rexp = !b && capn && (mv[1:0] != 2'b01);
          fexp = !b && capn && (mv[1:0] != 2'b00);
          pin_edge(1'b1, 16'h1111);
          if (rexp) exp_reg = 16'h1111;
          check(evt_o == rexp, capn ? "R5" : "R7", $sformatf("rise flag mode %0d buf %0d", m, b), evt_o, rexp);
          check(reg_o == exp_reg, capn ? "R5" : "R7", $sformatf("rise value mode %0d", m), reg_o, exp_reg);
          tick();
          check(evt_o == 0, "R8", $sformatf("rise pulse ends mode %0d", m), evt_o, 0);
          pin_edge(1'b0, 16'h2222);
          if (fexp) exp_reg = 16'h2222;
          check(evt_o == fexp, capn ? "R5" : "R7", $sformatf("fall flag mode %0d buf %0d", m, b), evt_o, fexp);
          check(reg_o == exp_reg, capn ? "R5" : "R7", $sformatf("fall value mode %0d", m), reg_o, exp_reg);
          tick();
          // neighbour strobe, divided clock
          cnt_i = 16'h3333; nbr_cnt_stb_i = 1'b1; nbr_undiv_i = 1'b0;
          tick();
          nbr_cnt_stb_i = 1'b0;
          rexp = !b && !capn;
          if (rexp) exp_reg = 16'h3333;
          check(evt_o == rexp, b ? "R6" : "R7", $sformatf("strobe flag mode %0d", m), evt_o, rexp);
          check(reg_o == exp_reg, b ? "R6" : "R7", $sformatf("strobe value mode %0d", m), reg_o, exp_reg);
          // neighbour strobe, undivided clock: suppressed
          cnt_i = 16'h4444; nbr_cnt_stb_i = 1'b1; nbr_undiv_i = 1'b1;
          tick();
          nbr_cnt_stb_i = 1'b0; nbr_undiv_i = 1'b0;
          check(evt_o == 0 && reg_o == exp_reg, "R7", $sformatf("undivided strobe mode %0d", m),
                reg_o, exp_reg);
        end
      end
    end

    // R9: write wins over a simultaneous capture
    buf_mode_i = 1'b0;
    set_mode(4'b1100);
    cnt_i = 16'h5555; nbr_cnt_stb_i = 1'b1;
    reg_wr_en_i = 1'b1; reg_wr_data_i = 16'h6666;
    tick();
    nbr_cnt_stb_i = 1'b0; reg_wr_en_i = 1'b0;
    check(reg_o == 16'h6666, "R9", "write beats capture", reg_o, 16'h6666);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule